// File: doc/BRIEF.md
# Indirect Register Access Port

This block lets a host reach two internal register banks through one small address window. The first bank holds the MAC control and status registers. The second holds the bus-interface configuration registers. Both banks share one address pointer. Each bank has its own data port. The host writes the pointer first. It then reads or writes the data port of the bank it wants, and that access reaches the register the pointer selects.

The window can be decoded in I/O space, in memory space, or in both at once. Each space has its own base and its own enable bit. The window spans 32 bytes, and a base is compared on address bits 31 to 5. After a hard reset the port works with 16-bit accesses. Software can move it to 32-bit accesses, and it then stays in 32-bit mode until the next hard reset.

The banks are stub arrays of 16-bit registers. They are built to map onto block RAM, so a reset does not clear their contents.

Top module: `regwin_port`

## Requirements
- R1: An access in I/O space (acc_mem=0) reaches the window only when io_en=1 and acc_addr[31:5] equals io_base[31:5]. An access in memory space (acc_mem=1) reaches the window only when mem_en=1 and acc_addr[31:5] equals mem_base[31:5]. When both enables are set, both spaces decode at the same time.
- R2: In word mode, 16-bit accesses (acc_dw=0) use these window offsets: 0x10 for the control/status data port, 0x12 for the pointer, and 0x16 for the bus-configuration data port.
- R3: In word mode, a 32-bit write (acc_dw=1) to offset 0x10 moves the port into doubleword mode and has no other effect. In doubleword mode, 32-bit accesses use 0x10 for the control/status data port, 0x14 for the pointer and 0x1C for the bus-configuration data port. Doubleword mode stays set through soft reset and clears only on rst.
- R4: An access whose size does not match the current mode is ignored. It produces no read response and changes no state. The single exception is the mode switch in R3. An access to any other offset is also ignored.
- R5: A write to the pointer offset stores acc_wdata[7:0]. A read of the pointer offset returns the pointer, zero-extended to 32 bits.
- R6: A write to a bank's data port stores acc_wdata[15:0] into the register the pointer selects, in that bank only. A read returns that register, zero-extended to 32 bits.
- R7: When the pointer is 128 or higher, data-port reads return zero and data-port writes change no register.
- R8: rd_valid is high for exactly one cycle. That cycle is the one after a read that hit a port, and rd_data carries the value in that cycle. Writes and ignored accesses produce no rd_valid.
- R9: rst clears the pointer, the mode and rd_valid. soft_rst clears only the pointer, and it overrides a pointer write in the same cycle. A read in the same cycle as soft_rst still uses the old pointer.
- R10: Asserting stop_cmd leaves the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hard reset |
| soft_rst | input | 1 | Software reset, clears the pointer |
| stop_cmd | input | 1 | Controller stop command, does not affect the pointer |
| io_en | input | 1 | Enables I/O-space decode |
| mem_en | input | 1 | Enables memory-space decode |
| io_base | input | 32 | I/O base address (bits 31:5 compared) |
| mem_base | input | 32 | Memory base address (bits 31:5 compared) |
| acc_valid | input | 1 | Host access this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_mem | input | 1 | 1 = memory space, 0 = I/O space |
| acc_dw | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| acc_addr | input | 32 | Access address |
| acc_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 32 | Read response data |

## Verification
Two events can meet in one cycle: a soft reset and a pointer write. A soft reset can also arrive with a data-port read that depends on the old pointer. Directed steps drive both pairs together, and random stimulus also lays soft_rst and stop_cmd over host accesses. A reference model in the bench applies the read and the write first and the pointer clear after them. Each response and each later pointer read-back is compared with that model.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

  // Window geometry: 32-byte window, base compared above this bit
  localparam int WIN_LSB = 5;

  // Port offsets in 16-bit mode
  localparam logic [WIN_LSB-1:0] OFS_W_CSR = 5'h10;
  localparam logic [WIN_LSB-1:0] OFS_W_PTR = 5'h12;
  localparam logic [WIN_LSB-1:0] OFS_W_BCR = 5'h16;

  // Port offsets in 32-bit mode
  localparam logic [WIN_LSB-1:0] OFS_D_CSR = 5'h10;
  localparam logic [WIN_LSB-1:0] OFS_D_PTR = 5'h14;
  localparam logic [WIN_LSB-1:0] OFS_D_BCR = 5'h1C;

  // Number of register banks behind the window
  localparam int NUM_BANKS = 2;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CSR  = 2'd1,
    SEL_PTR  = 2'd2,
    SEL_BCR  = 2'd3
  } port_sel_e;

endpackage

// File: rtl/regwin_decode.sv
module regwin_decode
  import regwin_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              acc_valid,
  input  logic              acc_wr,
  input  logic              acc_mem,
  input  logic              acc_dw,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [ADDR_W-1:0] io_base,
  input  logic [ADDR_W-1:0] mem_base,
  input  logic              io_en,
  input  logic              mem_en,
  input  logic              dw_mode,
  output port_sel_e         sel,
  output logic              mode_sw
);

  logic io_hit, mem_hit, win_hit;
  logic [WIN_LSB-1:0] ofs;

  assign io_hit  = !acc_mem && io_en &&
                   (acc_addr[ADDR_W-1:WIN_LSB] == io_base[ADDR_W-1:WIN_LSB]);
  assign mem_hit = acc_mem && mem_en &&
                   (acc_addr[ADDR_W-1:WIN_LSB] == mem_base[ADDR_W-1:WIN_LSB]);
  assign win_hit = acc_valid && (io_hit || mem_hit);
  assign ofs     = acc_addr[WIN_LSB-1:0];

  always_comb begin
    sel     = SEL_NONE;
    mode_sw = 1'b0;
    if (win_hit) begin
      if (dw_mode) begin
        if (acc_dw) begin
          unique case (ofs)
            OFS_D_CSR: sel = SEL_CSR;
            OFS_D_PTR: sel = SEL_PTR;
            OFS_D_BCR: sel = SEL_BCR;
            default:   sel = SEL_NONE;
          endcase
        end
      end else begin
        if (!acc_dw) begin
          unique case (ofs)
            OFS_W_CSR: sel = SEL_CSR;
            OFS_W_PTR: sel = SEL_PTR;
            OFS_W_BCR: sel = SEL_BCR;
            default:   sel = SEL_NONE;
          endcase
        end else if (acc_wr && ofs == OFS_D_CSR) begin
          mode_sw = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/regwin_ctl.sv
module regwin_ctl #(
  parameter int PTR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             soft_rst,
  input  logic             ptr_we,
  input  logic [PTR_W-1:0] ptr_wdata,
  input  logic             mode_sw,
  output logic [PTR_W-1:0] ptr_q,
  output logic             dw_mode
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q   <= '0;
      dw_mode <= 1'b0;
    end else begin
      if (soft_rst)
        ptr_q <= '0;
      else if (ptr_we)
        ptr_q <= ptr_wdata;
      if (mode_sw)
        dw_mode <= 1'b1;
    end
  end

  // R9
  ptr_clr_chk: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (ptr_q == '0));

  // R3
  dw_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    dw_mode |=> dw_mode);

endmodule

// File: rtl/regwin_bank.sv
module regwin_bank #(
  parameter int DEPTH = 128,
  parameter int WIDTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we)
      mem[idx] <= wdata;
    rdata <= mem[idx];
  end

endmodule

// File: rtl/regwin_port.sv
module regwin_port
  import regwin_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int REG_W      = 16,
  parameter int BANK_DEPTH = 128,
  parameter int PTR_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              stop_cmd,
  input  logic              io_en,
  input  logic              mem_en,
  input  logic [ADDR_W-1:0] io_base,
  input  logic [ADDR_W-1:0] mem_base,
  input  logic              acc_valid,
  input  logic              acc_wr,
  input  logic              acc_mem,
  input  logic              acc_dw,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);

  localparam int IDX_W = $clog2(BANK_DEPTH);

  port_sel_e        sel;
  logic             mode_sw;
  logic             dw_mode;
  logic [PTR_W-1:0] ptr_q;
  logic             ptr_we;
  logic             ptr_oor;
  logic [IDX_W-1:0] idx;

  logic [NUM_BANKS-1:0] bank_we;
  logic [REG_W-1:0]     bank_q [NUM_BANKS];

  port_sel_e        rsel_q;
  logic             roor_q;
  logic [PTR_W-1:0] rptr_q;
  logic             rvalid_q;

  regwin_decode #(.ADDR_W(ADDR_W)) u_decode (
    .acc_valid (acc_valid),
    .acc_wr    (acc_wr),
    .acc_mem   (acc_mem),
    .acc_dw    (acc_dw),
    .acc_addr  (acc_addr),
    .io_base   (io_base),
    .mem_base  (mem_base),
    .io_en     (io_en),
    .mem_en    (mem_en),
    .dw_mode   (dw_mode),
    .sel       (sel),
    .mode_sw   (mode_sw)
  );

  assign ptr_we = (sel == SEL_PTR) && acc_wr;

  regwin_ctl #(.PTR_W(PTR_W)) u_ctl (
    .clk       (clk),
    .rst       (rst),
    .soft_rst  (soft_rst),
    .ptr_we    (ptr_we),
    .ptr_wdata (acc_wdata[PTR_W-1:0]),
    .mode_sw   (mode_sw),
    .ptr_q     (ptr_q),
    .dw_mode   (dw_mode)
  );

  assign ptr_oor = ({1'b0, ptr_q} >= (PTR_W+1)'(BANK_DEPTH));
  assign idx     = ptr_q[IDX_W-1:0];

  assign bank_we[0] = (sel == SEL_CSR) && acc_wr && !ptr_oor;
  assign bank_we[1] = (sel == SEL_BCR) && acc_wr && !ptr_oor;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    regwin_bank #(.DEPTH(BANK_DEPTH), .WIDTH(REG_W)) u_bank (
      .clk   (clk),
      .we    (bank_we[g]),
      .idx   (idx),
      .wdata (acc_wdata[REG_W-1:0]),
      .rdata (bank_q[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid_q <= 1'b0;
      rsel_q   <= SEL_NONE;
      roor_q   <= 1'b0;
      rptr_q   <= '0;
    end else begin
      rvalid_q <= acc_valid && !acc_wr && (sel != SEL_NONE);
      rsel_q   <= sel;
      roor_q   <= ptr_oor;
      rptr_q   <= ptr_q;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rvalid_q) begin
      unique case (rsel_q)
        SEL_CSR: rd_data = roor_q ? '0 : {{(DATA_W-REG_W){1'b0}}, bank_q[0]};
        SEL_BCR: rd_data = roor_q ? '0 : {{(DATA_W-REG_W){1'b0}}, bank_q[1]};
        SEL_PTR: rd_data = {{(DATA_W-PTR_W){1'b0}}, rptr_q};
        default: rd_data = '0;
      endcase
    end
  end

  assign rd_valid = rvalid_q;

  // R8
  rd_src_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(acc_valid && !acc_wr));

  // R7
  oor_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (|bank_we) |-> ({1'b0, ptr_q} < (PTR_W+1)'(BANK_DEPTH)));

  // R10
  stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (stop_cmd && !soft_rst && !ptr_we) |=> $stable(ptr_q));

endmodule

// File: tb/regwin_port_bench.sv
module regwin_port_bench;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] IO_BASE  = 32'h0000_0300;
  localparam logic [31:0] MEM_BASE = 32'hFE00_1000;

  logic        clk = 1'b0;
  logic        rst, soft_rst, stop_cmd, io_en, mem_en;
  logic [31:0] io_base, mem_base;
  logic        acc_valid, acc_wr, acc_mem, acc_dw;
  logic [31:0] acc_addr, acc_wdata;
  logic        rd_valid;
  logic [31:0] rd_data;

  int checks = 0;
  int errs   = 0;
  bit done   = 0;

  logic [15:0] m_csr [128];
  logic [15:0] m_bcr [128];
  logic [7:0]  m_ptr;
  bit          m_dw;

  always #(CLK_PERIOD/2) clk = ~clk;

  regwin_port u_regwin_port (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .stop_cmd(stop_cmd),
    .io_en(io_en), .mem_en(mem_en), .io_base(io_base), .mem_base(mem_base),
    .acc_valid(acc_valid), .acc_wr(acc_wr), .acc_mem(acc_mem), .acc_dw(acc_dw),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  // 0 none, 1 csr, 2 ptr, 3 bcr, 4 mode switch
  function automatic int ref_dec(bit mem, bit dw, bit wr, logic [31:0] a);
    bit hit;
    logic [4:0] o;
    hit = mem ? (mem_en && a[31:5] == mem_base[31:5])
              : (io_en && a[31:5] == io_base[31:5]);
    o = a[4:0];
    if (!hit) return 0;
    if (m_dw) begin
      if (!dw) return 0;
      if (o == 5'h10) return 1;
      if (o == 5'h14) return 2;
      if (o == 5'h1C) return 3;
      return 0;
    end
    if (dw) return (wr && o == 5'h10) ? 4 : 0;
    if (o == 5'h10) return 1;
    if (o == 5'h12) return 2;
    if (o == 5'h16) return 3;
    return 0;
  endfunction

  function automatic string tag_of(int k);
    case (k)
      1, 3:    return "R6";
      2:       return "R5";
      4:       return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic access(bit mem, bit wr, bit dw, logic [31:0] a, logic [31:0] wd,
                        bit srst, bit stp, string tag);
    int k;
    bit ev;
    logic [31:0] ed;
    k = ref_dec(mem, dw, wr, a);
    ev = 0; ed = '0;
    case (k)
      1, 3: begin
        if (wr) begin
          if (m_ptr < 8'd128) begin
            if (k == 1) m_csr[m_ptr[6:0]] = wd[15:0];
            else        m_bcr[m_ptr[6:0]] = wd[15:0];
          end
        end else begin
          ev = 1;
          if (m_ptr < 8'd128)
            ed = {16'h0, (k == 1) ? m_csr[m_ptr[6:0]] : m_bcr[m_ptr[6:0]]};
        end
      end
      2: begin
        if (wr) m_ptr = wd[7:0];
        else begin ev = 1; ed = {24'h0, m_ptr}; end
      end
      4: m_dw = 1;
      default: ;
    endcase
    if (srst) m_ptr = '0;
    @(negedge clk);
    acc_valid = 1; acc_mem = mem; acc_wr = wr; acc_dw = dw;
    acc_addr = a; acc_wdata = wd; soft_rst = srst; stop_cmd = stp;
    @(posedge clk);
    @(negedge clk);
    acc_valid = 0; soft_rst = 0; stop_cmd = 0;
    check({tag, " R8 valid"}, {31'h0, rd_valid}, {31'h0, ev});
    if (ev) check({tag, " data"}, rd_data, ed);
  endtask

  task automatic hard_reset();
    @(negedge clk);
    rst = 1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst = 0;
    m_ptr = '0; m_dw = 0;
  endtask

  function automatic logic [31:0] w_addr(logic [31:0] b, logic [4:0] o);
    return {b[31:5], o};
  endfunction

  initial begin
    rst = 1; soft_rst = 0; stop_cmd = 0; io_en = 1; mem_en = 0;
    io_base = IO_BASE; mem_base = MEM_BASE;
    acc_valid = 0; acc_wr = 0; acc_mem = 0; acc_dw = 0; acc_addr = '0; acc_wdata = '0;
    m_ptr = '0; m_dw = 0;
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R9 reset state
    check("R9 rd_valid after reset", {31'h0, rd_valid}, 32'h0);
    access(0, 0, 0, w_addr(IO_BASE, 5'h12), 0, 0, 0, "R9 ptr after reset");

    // fill both banks in word mode (R2, R5, R6)
    for (int i = 0; i < 128; i++) begin
      access(0, 1, 0, w_addr(IO_BASE, 5'h12), i, 0, 0, "R5");
      access(0, 1, 0, w_addr(IO_BASE, 5'h10), 32'hA000 + i * 3, 0, 0, "R6");
      access(0, 1, 0, w_addr(IO_BASE, 5'h16), 32'h5000 ^ (i * 7), 0, 0, "R6");
    end
    access(0, 1, 0, w_addr(IO_BASE, 5'h12), 32'h1234_5605, 0, 0, "R5 ptr write");
    access(0, 0, 0, w_addr(IO_BASE, 5'h12), 0, 0, 0, "R5 ptr readback");
    access(0, 0, 0, w_addr(IO_BASE, 5'h10), 0, 0, 0, "R2 csr read");
    access(0, 0, 0, w_addr(IO_BASE, 5'h16), 0, 0, 0, "R2 bcr read");
    access(0, 0, 0, w_addr(IO_BASE, 5'h14), 0, 0, 0, "R2 wrong offset");
    // R1 memory space disabled, then both live
    access(1, 0, 0, w_addr(MEM_BASE, 5'h10), 0, 0, 0, "R1 mem disabled");
    mem_en = 1;
    access(1, 0, 0, w_addr(MEM_BASE, 5'h10), 0, 0, 0, "R1 mem enabled");
    access(0, 0, 0, w_addr(IO_BASE, 5'h10), 0, 0, 0, "R1 io still live");
    access(0, 0, 0, w_addr(IO_BASE + 32'h20, 5'h10), 0, 0, 0, "R1 io base miss");
    io_en = 0;
    access(0, 0, 0, w_addr(IO_BASE, 5'h10), 0, 0, 0, "R1 io disabled");
    io_en = 1;
    // R7 out of range pointer
    access(0, 1, 0, w_addr(IO_BASE, 5'h12), 32'h85, 0, 0, "R7 ptr");
    access(0, 0, 0, w_addr(IO_BASE, 5'h10), 0, 0, 0, "R7 oor read");
    access(0, 1, 0, w_addr(IO_BASE, 5'h10), 32'hDEAD, 0, 0, "R7 oor write");
    access(0, 1, 0, w_addr(IO_BASE, 5'h12), 32'h05, 0, 0, "R7 ptr");
    access(0, 0, 0, w_addr(IO_BASE, 5'h10), 0, 0, 0, "R7 alias unchanged");
    // R10 stop leaves pointer
    access(0, 0, 0, w_addr(IO_BASE, 5'h16), 0, 0, 1, "R10 read with stop");
    access(0, 0, 0, w_addr(IO_BASE, 5'h12), 0, 0, 0, "R10 ptr after stop");
    // R9 soft reset vs pointer write in same cycle, and read with soft reset
    access(0, 1, 0, w_addr(IO_BASE, 5'h12), 32'h22, 1, 0, "R9 srst+ptr write");
    access(0, 0, 0, w_addr(IO_BASE, 5'h12), 0, 0, 0, "R9 ptr cleared");
    access(0, 1, 0, w_addr(IO_BASE, 5'h12), 32'h09, 0, 0, "R9 ptr");
    access(0, 0, 0, w_addr(IO_BASE, 5'h10), 0, 1, 0, "R9 read uses old ptr");
    access(0, 0, 0, w_addr(IO_BASE, 5'h12), 0, 0, 0, "R9 ptr zero");
    // R4 size mismatch in word mode
    access(0, 0, 1, w_addr(IO_BASE, 5'h10), 0, 0, 0, "R4 dw read in word mode");
    access(0, 1, 1, w_addr(IO_BASE, 5'h14), 32'h33, 0, 0, "R4 dw write ignored");
    access(0, 0, 0, w_addr(IO_BASE, 5'h12), 0, 0, 0, "R4 ptr unchanged");
    // R3 switch to doubleword mode
    access(0, 1, 1, w_addr(IO_BASE, 5'h10), 32'hFFFF_FFFF, 0, 0, "R3 switch");
    access(0, 0, 0, w_addr(IO_BASE, 5'h12), 0, 0, 0, "R4 word read in dw mode");
    access(0, 1, 1, w_addr(IO_BASE, 5'h14), 32'h11, 0, 0, "R3 dw ptr write");
    access(0, 0, 1, w_addr(IO_BASE, 5'h14), 0, 0, 0, "R3 dw ptr read");
    access(0, 0, 1, w_addr(IO_BASE, 5'h10), 0, 0, 0, "R3 dw csr read");
    access(1, 0, 1, w_addr(MEM_BASE, 5'h1C), 0, 0, 0, "R3 dw bcr read");
    access(0, 0, 1, w_addr(IO_BASE, 5'h10), 0, 1, 0, "R3 srst keeps mode");
    access(0, 0, 1, w_addr(IO_BASE, 5'h14), 0, 0, 0, "R3 still dw");
    hard_reset();
    access(0, 0, 1, w_addr(IO_BASE, 5'h14), 0, 0, 0, "R9 rst leaves dw");
    access(0, 0, 0, w_addr(IO_BASE, 5'h12), 0, 0, 0, "R9 word mode again");

    // constrained random mix
    for (int n = 0; n < 600; n++) begin
      bit mem, wr, dw, srst, stp;
      logic [4:0] o;
      logic [31:0] b, wd;
      int k;
      mem  = $urandom_range(0, 1);
      wr   = $urandom_range(0, 1);
      dw   = $urandom_range(0, 1);
      srst = ($urandom_range(0, 19) == 0);
      stp  = ($urandom_range(0, 9) == 0);
      case ($urandom_range(0, 6))
        0: o = 5'h10; 1: o = 5'h12; 2: o = 5'h14;
        3: o = 5'h16; 4: o = 5'h1C; 5: o = 5'h10;
        default: o = 5'($urandom);
      endcase
      b = mem ? MEM_BASE : IO_BASE;
      if ($urandom_range(0, 15) == 0) b = b ^ 32'h0000_0100;
      wd = $urandom;
      if ($urandom_range(0, 7) != 0) wd[7] = 1'b0;
      if ($urandom_range(0, 31) == 0) begin
        io_en = $urandom_range(0, 1); mem_en = $urandom_range(0, 1);
      end
      k = ref_dec(mem, dw, wr, w_addr(b, o));
      access(mem, wr, dw, w_addr(b, o), wd, srst, stp, tag_of(k));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule